// File: doc/BRIEF.md
# Periodic Memory Scrubbing Controller

This block sits between a user port and an error-correcting codec that fronts a memory array. A programmable period timer raises a scrub request at a fixed interval. When the request is serviced, the block takes over the codec's address and command path for one codeword. It issues a read so the codec decodes and corrects the stored word. It then issues a write so the codec stores the corrected, re-encoded word back at the same address. Successive scrubs walk through every codeword address in turn and wrap around at the end of the range.

The user side is told through a ready output when the memory cannot take new requests. A user access that has already been accepted is always allowed to finish before the scrub takes the bus. The codec and the memory are outside the block. They are reached through a level command request (with a write flag and an address) that is held until the codec answers with a one-cycle done pulse. Between the read command and the write command, the codec keeps the corrected word. Writing a period of zero turns scrubbing off, and zero is also the value after reset.

Top module: `mem_scrub_ctrl`

## Requirements
- R1: `usr_ready` is low in every cycle where `scrub_en` is high. It is also low while a period tick is pending and its scrub has not yet started.
- R2: While `scrub_en` is high, `cdc_addr` carries the scrub address and `usr_addr` has no effect on it. While `scrub_en` is low, `cdc_addr` follows `usr_addr`.
- R3: While `scrub_en` is high, the block drives `cdc_req` high itself, and `usr_req` and `usr_we` have no effect. In idle, `cdc_req` is `usr_req` gated by acceptance: the request is accepted when `usr_ready` is high, or it is already in flight.
- R4: Each scrub first holds a read command (`cdc_we`=0) until `cdc_done`. In the next cycle it holds a write command (`cdc_we`=1) to the same address until `cdc_done`.
- R5: A period value P, written with `cfg_wr`, produces a tick every P cycles. The tick count starts at the write. With no user traffic, the first `scrub_en` rise comes P+2 cycles after the cycle in which `cfg_wr` is high. Later rises come every P cycles.
- R6: A scrub never starts while an accepted user access is waiting for `cdc_done`. A pending tick starts its scrub two cycles after that access's done pulse.
- R7: The scrub address is 0 after reset. It advances by one after each write-back done, and wraps from NUM_CW-1 to 0.
- R8: A period of zero (the reset value) starts no scrub. A scrub that is already running completes.
- R9: In the cycle after the write-back `cdc_done`, `scrub_en` is low. `usr_ready` is high again unless another tick is already pending.
- R10: After reset, `usr_ready` is high, and `scrub_en` and `cdc_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Load strobe for the scrub period |
| cfg_period | input | PW | Scrub period in cycles, 0 disables |
| usr_req | input | 1 | User command request, held until done |
| usr_we | input | 1 | User command is a write |
| usr_addr | input | AW | User codeword address |
| usr_ready | output | 1 | Block can accept a new user request |
| scrub_en | output | 1 | Scrub owns the codec path (codec selects scrub address) |
| cdc_req | output | 1 | Command request to codec |
| cdc_we | output | 1 | Command is a write |
| cdc_addr | output | AW | Codeword address to codec |
| cdc_done | input | 1 | One-cycle completion pulse from codec |

## Verification
The bench builds the block with NUM_CW=5 and PW=8, and uses a codec model that answers every command three cycles after it is seen. With five codewords, the wrap from address 4 back to 0 is reached after only a few scrubs, and the range is not a power of two. The 8-bit period makes it cheap to cover short periods (including a period of 1, where ticks land during a scrub) and the zero-period disable. A behavioural model compares ready, enable, request, write flag and address on every cycle. This runs while back-to-back user accesses race against ticks.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_READ  = 2'd1,
    SC_WRITE = 2'd2
  } scrub_phase_e;

endpackage

// File: rtl/scrub_rst_sync.sv
module scrub_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/scrub_timer.sv
module scrub_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [PW-1:0] cfg_period,
  output logic          tick,
  output logic          period_zero
);

  logic [PW-1:0] period_q, period_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          period_en, cnt_en;

  // next-state
  always_comb begin
    period_zero = (period_q == '0);
    tick        = !period_zero && (cnt_q == period_q - 1'b1);
    period_en   = cfg_wr;
    period_d    = cfg_period;
    cnt_en      = cfg_wr || !period_zero;
    if (cfg_wr)    cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (period_en) period_q <= period_d;
      if (cnt_en)    cnt_q    <= cnt_d;
    end
  end

  // R5: the cycle counter never runs past the programmed period
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q != '0) |-> (cnt_q < period_q));

  // R8: a zero period holds the counter still
  a_r8_idle_counter: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(period_q) == '0 && !$past(cfg_wr)) |-> $stable(cnt_q));

endmodule

// File: rtl/scrub_addr_gen.sv
module scrub_addr_gen #(
  parameter int NUM_CW = 1024,
  parameter int AW     = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] LAST = AW'(NUM_CW - 1);

  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    if (addr_q == LAST) addr_d = '0;
    else                addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   addr_q <= '0;
    else if (adv) addr_q <= addr_d;
  end

  assign addr = addr_q;

  // R7: address stays inside the codeword range
  a_r7_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q <= LAST);

  // R7: wrap after the last codeword
  a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && addr_q == LAST) |=> (addr_q == '0));

endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
  import scrub_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          period_zero,
  input  logic          usr_req,
  input  logic          usr_we,
  input  logic [AW-1:0] usr_addr,
  input  logic [AW-1:0] scrub_addr,
  input  logic          cdc_done,
  output logic          usr_ready,
  output logic          scrub_en,
  output logic          cdc_req,
  output logic          cdc_we,
  output logic [AW-1:0] cdc_addr,
  output logic          adv
);

  scrub_phase_e state_q, state_d;
  logic         busy_q, busy_d;
  logic         pend_q, pend_d;
  logic         start;

  // next-state
  always_comb begin
    state_d = state_q;
    busy_d  = busy_q;
    adv     = 1'b0;
    start   = 1'b0;
    unique case (state_q)
      SC_IDLE: begin
        start = pend_q && !busy_q;
        if (start) state_d = SC_READ;
        if (busy_q) begin
          if (cdc_done) busy_d = 1'b0;
        end else if (usr_req && !pend_q && !cdc_done) begin
          busy_d = 1'b1;
        end
      end
      SC_READ: begin
        if (cdc_done) state_d = SC_WRITE;
      end
      SC_WRITE: begin
        if (cdc_done) begin
          state_d = SC_IDLE;
          adv     = 1'b1;
        end
      end
      default: state_d = SC_IDLE;
    endcase
    if (period_zero) pend_d = 1'b0;
    else if (tick)   pend_d = 1'b1;
    else if (start)  pend_d = 1'b0;
    else             pend_d = pend_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
      pend_q  <= pend_d;
    end
  end

  // outputs: bus ownership mux
  always_comb begin
    usr_ready = (state_q == SC_IDLE) && !pend_q;
    scrub_en  = (state_q != SC_IDLE);
    if (scrub_en) begin
      cdc_req  = 1'b1;
      cdc_we   = (state_q == SC_WRITE);
      cdc_addr = scrub_addr;
    end else begin
      cdc_req  = usr_req && (usr_ready || busy_q);
      cdc_we   = usr_we;
      cdc_addr = usr_addr;
    end
  end

  // R1: user is held off for the whole scrub
  a_r1_ready_low_in_scrub: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_en |-> !usr_ready);

  // R3: an unaccepted user request never reaches the codec
  a_r3_user_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!scrub_en && !usr_ready && !busy_q) |-> !cdc_req);

  // R4: read completion is followed by the write-back
  a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (scrub_en && !cdc_we && cdc_done) |=> (scrub_en && cdc_we && cdc_req));

  // R4: address held across the read and write of one scrub
  a_r4_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (scrub_en && $past(scrub_en)) |-> $stable(cdc_addr));

  // R6: no seizure while a user access is in flight
  a_r6_no_seize_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scrub_en) |-> !$past(busy_q));

  // R9: bus released one cycle after write-back done
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (scrub_en && cdc_we && cdc_done) |=> !scrub_en);

endmodule

// File: rtl/mem_scrub_ctrl.sv
module mem_scrub_ctrl #(
  parameter  int NUM_CW = 1024,
  parameter  int PW     = 16,
  localparam int AW     = (NUM_CW > 1) ? $clog2(NUM_CW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [PW-1:0] cfg_period,
  input  logic          usr_req,
  input  logic          usr_we,
  input  logic [AW-1:0] usr_addr,
  output logic          usr_ready,
  output logic          scrub_en,
  output logic          cdc_req,
  output logic          cdc_we,
  output logic [AW-1:0] cdc_addr,
  input  logic          cdc_done
);

  logic          rst_n_s;
  logic          tick;
  logic          period_zero;
  logic          adv;
  logic [AW-1:0] scrub_addr;

  scrub_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  scrub_timer #(.PW(PW)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .cfg_wr      (cfg_wr),
    .cfg_period  (cfg_period),
    .tick        (tick),
    .period_zero (period_zero)
  );

  scrub_addr_gen #(.NUM_CW(NUM_CW), .AW(AW)) u_addr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .adv   (adv),
    .addr  (scrub_addr)
  );

  scrub_seq #(.AW(AW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .tick        (tick),
    .period_zero (period_zero),
    .usr_req     (usr_req),
    .usr_we      (usr_we),
    .usr_addr    (usr_addr),
    .scrub_addr  (scrub_addr),
    .cdc_done    (cdc_done),
    .usr_ready   (usr_ready),
    .scrub_en    (scrub_en),
    .cdc_req     (cdc_req),
    .cdc_we      (cdc_we),
    .cdc_addr    (cdc_addr),
    .adv         (adv)
  );

endmodule

// File: tb/mem_scrub_ctrl_tb_top.sv
module mem_scrub_ctrl_tb_top;

  localparam int NCW = 5;
  localparam int PW  = 8;
  localparam int AW  = 3;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [PW-1:0] cfg_period = '0;
  logic          usr_req = 1'b0;
  logic          usr_we = 1'b0;
  logic [AW-1:0] usr_addr = '0;
  logic          usr_ready, scrub_en, cdc_req, cdc_we;
  logic [AW-1:0] cdc_addr;
  logic          cdc_done = 1'b0;

  always #5 clk = ~clk;

  mem_scrub_ctrl #(.NUM_CW(NCW), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_period(cfg_period),
    .usr_req(usr_req), .usr_we(usr_we), .usr_addr(usr_addr),
    .usr_ready(usr_ready), .scrub_en(scrub_en), .cdc_req(cdc_req),
    .cdc_we(cdc_we), .cdc_addr(cdc_addr), .cdc_done(cdc_done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // codec model: done pulse in the LAT-th cycle of each held command
  int c_cnt = 0;
  always @(posedge clk) begin
    #2;
    if (cdc_done) begin cdc_done = 1'b0; c_cnt = 0; end
    if (cdc_req) begin
      c_cnt++;
      if (c_cnt == LAT) cdc_done = 1'b1;
    end else c_cnt = 0;
  end

  // reference model state
  bit model_on = 0;
  int m_per = 0, m_cnt = 0, m_phase = 0, m_addr = 0;
  bit m_pend = 0, m_busy = 0, m_wr_done = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (model_on) begin
      bit tk, st;
      tk = (m_per != 0) && (m_cnt == m_per - 1);
      st = (m_phase == 0) && m_pend && !m_busy;
      m_wr_done = (m_phase == 2) && cdc_done;
      if (m_phase == 0) begin
        if (m_busy) begin
          if (cdc_done) m_busy = 0;
        end else if (usr_req && !m_pend && !cdc_done) m_busy = 1;
        if (st) m_phase = 1;
      end else if (m_phase == 1) begin
        if (cdc_done) m_phase = 2;
      end else if (cdc_done) begin
        m_phase = 0;
        m_addr = (m_addr + 1) % NCW;
      end
      if (m_per == 0) m_pend = 0;
      else if (tk)    m_pend = 1;
      else if (st)    m_pend = 0;
      if (cfg_wr) begin m_per = int'(cfg_period); m_cnt = 0; end
      else if (m_per != 0) m_cnt = tk ? 0 : m_cnt + 1;
    end
  end

  // per-cycle comparison and monitors
  bit en_prev = 0;
  bit u_inflight = 0;
  int w_cyc = 0;
  int rise_cyc[$];
  int rise_addr[$];

  always @(negedge clk) begin
    if (model_on) begin
      bit e_ready, e_en, e_req, e_we;
      int e_addr;
      e_ready = (m_phase == 0) && !m_pend;
      e_en    = (m_phase != 0);
      e_req   = e_en ? 1'b1 : (usr_req && (e_ready || m_busy));
      e_we    = (m_phase == 2) ? 1'b1 : (m_phase == 1) ? 1'b0 : usr_we;
      e_addr  = e_en ? m_addr : int'(usr_addr);
      chk("R1 usr_ready", usr_ready, e_ready);
      chk("R2 scrub_en", scrub_en, e_en);
      chk("R3 cdc_req", cdc_req, e_req);
      chk("R4 cdc_we", cdc_we, e_we);
      chk("R2/R7 cdc_addr", cdc_addr, e_addr);
      if (m_wr_done) chk("R9 enable low after write-back", scrub_en, 0);
      if (cfg_wr) w_cyc = cyc;
      if (scrub_en && !en_prev) begin
        chk("R6 no user access in flight at scrub start", u_inflight, 0);
        rise_cyc.push_back(cyc);
        rise_addr.push_back(int'(cdc_addr));
      end
      en_prev = scrub_en;
    end
  end

  task automatic cfg(input int p);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_period = PW'(p);
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic user_access(input bit we, input int a);
    bit acc;
    acc = 0;
    @(posedge clk); #1;
    usr_req = 1'b1; usr_we = we; usr_addr = AW'(a);
    forever begin
      @(negedge clk);
      if (!acc && usr_ready) begin acc = 1; u_inflight = 1; end
      if (acc && cdc_done) break;
    end
    @(posedge clk); #1;
    usr_req = 1'b0; u_inflight = 0;
    usr_we = ~usr_we; usr_addr = usr_addr + 3'd3;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int first;
    int cnt_en;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    model_on = 1;
    idle(4);
    @(negedge clk);
    // R10: reset state
    chk("R10 ready after reset", usr_ready, 1);
    chk("R10 enable after reset", scrub_en, 0);
    chk("R10 request after reset", cdc_req, 0);

    // R8: zero period, user traffic only
    user_access(1'b1, 2);
    user_access(1'b0, 6);
    first = rise_cyc.size();
    idle(40);
    chk("R8 no scrub at zero period", rise_cyc.size() - first, 0);

    // R5: period 20, no user traffic
    cfg(20);
    idle(70);
    chk("R5 first scrub P+2 after write", rise_cyc[first] - w_cyc, 22);
    chk("R5 second scrub one period later", rise_cyc[first+1] - rise_cyc[first], 20);
    chk("R5 third scrub one period later", rise_cyc[first+2] - rise_cyc[first+1], 20);

    // R6/R3: user traffic racing against a short period
    cfg(12);
    for (int i = 0; i < 25; i++) user_access(i[0], i * 5);

    // period 1: ticks land during scrubs, user waits
    cfg(1);
    fork
      user_access(1'b1, 1);
      idle(30);
    join_any
    cfg(0);
    wait (u_inflight == 0 && usr_req == 1'b0);
    idle(20);

    // R8: disabled mid-run, no further scrubs
    cnt_en = rise_cyc.size();
    idle(60);
    chk("R8 no scrub after disable", rise_cyc.size() - cnt_en, 0);
    chk("R9 ready restored when idle", usr_ready, 1);

    // R7: walk and wrap of the scrub address
    chk("R7 enough scrubs for a wrap", rise_cyc.size() > NCW, 1);
    foreach (rise_addr[i]) chk("R7 scrub address sequence", rise_addr[i], i % NCW);

    finish_run();
  end

endmodule